// File: doc/BRIEF.md
# Background Channel Scan Sequencer

This block runs a background measurement loop over up to eight analog channels that share one converter. Software enables channels with a bitmap. It selects the autonomous conversion mode and sets a run bit. The block then visits the enabled channels in ascending order and wraps back to the lowest one after the highest. For each channel it asks the converter for a conversion and holds the request until the converter answers. It keeps the returned 12-bit sample as that channel's latest value.

After each sample a programmable quiet period passes before the next channel is visited. A two-bit code selects that period from four lengths, each twice the one before. Channels whose pins are muxed as general-purpose outputs are left out of the scan. A one-cycle strobe carries each new sample with its channel number. Any channel's latest value can be read combinationally through a select input.

Top module: `scan_sequencer`

## Requirements
- R1: Bit i of `chan_enable` enables channel i. Enabled channels are converted in ascending channel order, and the scan wraps from the highest enabled channel back to the lowest.
- R2: Conversion requests are issued only while `conv_mode` equals 2'd1 and `scan_start` is 1. With `conv_mode` at 0, 2 or 3, `conv_req` stays low.
- R3: When `scan_start` is cleared, the cycle that follows has `conv_req` low, and no further request is issued while it stays clear.
- R4: An `interval_sel` code k gives a quiet period of (750 << k) × CYC_PER_US clock cycles, that is 0.75, 1.5, 3 or 6 ms. `conv_req` rises exactly that many cycles plus one after the `res_valid` strobe.
- R5: A completed conversion's sample is stored as that channel's latest value. `latest_value` shows the stored sample of channel `latest_sel` in the same cycle.
- R6: A channel whose `pin_is_output` bit is 1 is never requested, even when it is enabled. Bit value 0 marks an analog input.
- R7: Samples and stored values are 12 bits wide. All stored values read 0 after reset, and `conv_req` and `res_valid` are low out of reset.
- R8: A rising edge of `scan_start`, or any change of `chan_enable`, restarts the scan at the lowest effective channel.
- R9: When no channel is both enabled and configured as an input, no conversion is requested.
- R10: `res_valid` is high for exactly one cycle, in the cycle after `conv_done` is sampled high. It carries the channel on `res_chan` and the sample on `res_data`.
- R11: Once raised, `conv_req` stays high with a stable `conv_chan` until `conv_done` is sampled, unless the scan is halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_enable | input | 8 | Channels selected for the scan |
| pin_is_output | input | 8 | 1 marks a channel's pin as a general-purpose output |
| conv_mode | input | 2 | Conversion mode; 1 selects autonomous scanning |
| scan_start | input | 1 | Run bit for the scan |
| interval_sel | input | 2 | Quiet-period code |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | 3 | Channel to convert |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | 12 | Converter sample, valid with conv_done |
| res_valid | output | 1 | One-cycle new-sample strobe |
| res_chan | output | 3 | Channel of the new sample |
| res_data | output | 12 | New sample value |
| latest_sel | input | 3 | Channel whose latest value is read |
| latest_value | output | 12 | Latest stored sample of latest_sel |

## Verification
Two situations are hard to reach: a halt that lands in the middle of a quiet period, and a restart that must abandon a scan position part-way through the channel list. The bench reaches the first by dropping the run bit right after a result strobe and then watching a window longer than the longest period. It reaches the second by collecting two samples from a sparse bitmap, toggling the run bit, and requiring the next sample to come from the lowest channel again. Making the clock-per-microsecond parameter small keeps the full interval table within reach, so every code's exact gap can be measured.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_e;

  localparam logic [1:0] MODE_AUTO  = 2'd1;
  localparam int         BASE_GAP_US = 750;

  // Quiet period length in clock cycles for a two-bit code
  function automatic int unsigned gap_cycles(input logic [1:0] code,
                                             input int unsigned cyc_per_us);
    return (BASE_GAP_US << code) * cyc_per_us;
  endfunction

  // Next index with wrap-around
  function automatic int unsigned wrap_inc(input int unsigned idx,
                                           input int unsigned n);
    return (idx == n - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/gap_timer.sv
module gap_timer
  import scan_seq_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       abort,
  input  logic [1:0] code,
  output logic       busy,
  output logic       expire
);
  localparam int unsigned MAX_CYC = BASE_GAP_US * 8 * CYC_PER_US;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(gap_cycles(code, CYC_PER_US) - 1);
  assign expire   = busy && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      count <= '0;
    end else if (abort) begin
      busy  <= 1'b0;
      count <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      count <= load_val;
    end else if (busy) begin
      if (count == '0) busy <= 1'b0;
      else             count <= count - 1'b1;
    end
  end

  // R4: the count never exceeds the longest period
  p_gap_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (count < CNT_W'(MAX_CYC)));

  // R4: a running count moves down by one each cycle
  p_gap_counts_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !expire && !load && !abort) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/chan_picker.sv
module chan_picker #(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] eff_mask,
  input  logic [CH_W-1:0]   base,
  output logic              any,
  output logic [CH_W-1:0]   pick
);
  always_comb begin
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      int unsigned idx;
      idx = int'(base) + i;
      if (idx >= NUM_CH) idx = idx - NUM_CH;
      if (eff_mask[idx]) pick = CH_W'(idx);
    end
  end

  assign any = |eff_mask;

  // R1: the chosen channel is one that is enabled
  always_comb begin
    if (any) a_pick_enabled_r1: assert (eff_mask[pick]);
  end

endmodule

// File: rtl/latest_store.sv
module latest_store #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned RES_W  = 12,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_chan,
  input  logic [RES_W-1:0] wr_data,
  input  logic [CH_W-1:0]  rd_sel,
  output logic [RES_W-1:0] rd_data
);
  logic [RES_W-1:0] slot [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 slot[g] <= '0;
      else if (wr_en && (wr_chan == CH_W'(g)))    slot[g] <= wr_data;
    end
  end

  assign rd_data = slot[rd_sel];

  // R5: a channel not written keeps its value
  p_slot_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(slot[0]) && $stable(slot[NUM_CH-1]));

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_seq_pkg::*;
#(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned RES_W      = 12,
  parameter int unsigned CYC_PER_US = 100,
  localparam int unsigned CH_W      = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chan_enable,
  input  logic [NUM_CH-1:0] pin_is_output,
  input  logic [1:0]        conv_mode,
  input  logic              scan_start,
  input  logic [1:0]        interval_sel,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              res_valid,
  output logic [CH_W-1:0]   res_chan,
  output logic [RES_W-1:0]  res_data,
  input  logic [CH_W-1:0]   latest_sel,
  output logic [RES_W-1:0]  latest_value
);
  seq_state_e        state;
  logic [CH_W-1:0]   cursor;
  logic [CH_W-1:0]   cur_chan;
  logic [NUM_CH-1:0] enable_q;
  logic              start_q;

  // Named internal events
  logic [NUM_CH-1:0] eff_mask;
  logic              run;
  logic              restart;
  logic              any_eff;
  logic [CH_W-1:0]   next_chan;
  logic              sample_taken;
  logic              gap_load;
  logic              gap_busy;
  logic              gap_expire;
  logic              halt;

  assign eff_mask     = chan_enable & ~pin_is_output;
  assign run          = (conv_mode == MODE_AUTO) && scan_start;
  assign restart      = (chan_enable != enable_q) || (scan_start && !start_q);
  assign halt         = !run || restart;
  assign sample_taken = (state == ST_CONV) && conv_done && !halt;
  assign gap_load     = sample_taken;

  chan_picker #(.NUM_CH(NUM_CH)) u_pick (
    .eff_mask (eff_mask),
    .base     (cursor),
    .any      (any_eff),
    .pick     (next_chan)
  );

  gap_timer #(.CYC_PER_US(CYC_PER_US)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (gap_load),
    .abort  (halt),
    .code   (interval_sel),
    .busy   (gap_busy),
    .expire (gap_expire)
  );

  latest_store #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sample_taken),
    .wr_chan (cur_chan),
    .wr_data (conv_data),
    .rd_sel  (latest_sel),
    .rd_data (latest_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      start_q  <= 1'b0;
    end else begin
      enable_q <= chan_enable;
      start_q  <= scan_start;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cursor   <= '0;
      cur_chan <= '0;
    end else if (halt) begin
      state  <= ST_IDLE;
      cursor <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (any_eff) begin
          state    <= ST_CONV;
          cur_chan <= next_chan;
        end
        ST_CONV: if (conv_done) begin
          state  <= ST_GAP;
          cursor <= CH_W'(wrap_inc(int'(cur_chan), NUM_CH));
        end
        ST_GAP: if (gap_expire) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_chan  <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= sample_taken;
      if (sample_taken) begin
        res_chan <= cur_chan;
        res_data <= conv_data;
      end
    end
  end

  assign conv_req  = (state == ST_CONV);
  assign conv_chan = cur_chan;

  // R3: a stopped scan drops its request on the next cycle
  p_halt_drops_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !conv_req);

  // R6: a live request never targets an output pin or disabled channel
  p_req_target_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && run && !restart) |-> (chan_enable[conv_chan] && !pin_is_output[conv_chan]));

  // R9: nothing to scan means no request appears from idle
  p_empty_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && eff_mask == '0) |=> !conv_req);

  // R10: the result strobe lasts a single cycle
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R11: a request waits, unchanged, for its completion
  p_req_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done && !halt) |=> (conv_req && $stable(conv_chan)));

  // R4: the gap timer runs while waiting between channels
  p_gap_runs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> gap_busy);

endmodule

// File: tb/scan_sequencer_test.sv
module scan_sequencer_test;
  localparam int NCH  = 8;
  localparam int CPU  = 1;
  localparam int CLAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  chan_enable = '0;
  logic [7:0]  pin_is_output = '0;
  logic [1:0]  conv_mode = 2'd0;
  logic        scan_start = 1'b0;
  logic [1:0]  interval_sel = 2'd0;
  logic        conv_req;
  logic [2:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic        res_valid;
  logic [2:0]  res_chan;
  logic [11:0] res_data;
  logic [2:0]  latest_sel = '0;
  logic [11:0] latest_value;

  int checks = 0;
  int fails  = 0;
  int nconv  = 0;
  logic [11:0] sent_data;
  logic [2:0]  sent_chan;

  always #2 clk = ~clk;

  scan_sequencer #(.CYC_PER_US(CPU)) uut (
    .clk(clk), .rst_n(rst_n), .chan_enable(chan_enable),
    .pin_is_output(pin_is_output), .conv_mode(conv_mode),
    .scan_start(scan_start), .interval_sel(interval_sel),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_data(conv_data), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .latest_sel(latest_sel), .latest_value(latest_value)
  );

  // Converter model: answers a held request after CLAT cycles
  initial begin
    forever begin
      @(negedge clk);
      if (conv_req) begin
        repeat (CLAT - 1) @(negedge clk);
        if (conv_req) begin
          sent_chan = conv_chan;
          sent_data = {conv_chan, 1'b1, nconv[7:0]};
          conv_data = sent_data;
          conv_done = 1'b1;
          @(negedge clk);
          conv_done = 1'b0;
          nconv++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int next_exp(input logic [7:0] eff, input int from);
    for (int i = 0; i < NCH; i++) begin
      if (eff[(from + i) % NCH]) return (from + i) % NCH;
    end
    return -1;
  endfunction

  function automatic int gap_len(input logic [1:0] code);
    return 750 * (1 << code) * CPU;
  endfunction

  task automatic wait_result();
    int n = 0;
    while (!res_valid && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic count_to_req(output int n);
    n = 0;
    while (!conv_req && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic quiet_window(input int len, output int reqs);
    reqs = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (conv_req) reqs++;
    end
  endtask

  // {enable, pin_is_output, interval}
  localparam logic [17:0] VEC [4] = '{
    {8'hFF, 8'h00, 2'd0},
    {8'h81, 8'h00, 2'd1},
    {8'hF0, 8'h50, 2'd2},
    {8'h0A, 8'h02, 2'd3}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int exp_ch, gap, reqs;
    logic [7:0] eff;
    repeat (3) @(negedge clk);
    // R7: reset state
    latest_sel = 3'd3;
    #1;
    chk(conv_req == 1'b0, "R7 req after reset", conv_req, 0);
    chk(res_valid == 1'b0, "R7 valid after reset", res_valid, 0);
    chk(latest_value == 12'd0, "R7 latest after reset", latest_value, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: mode 0 never requests
    chan_enable = 8'hFF; conv_mode = 2'd0; scan_start = 1'b1;
    quiet_window(300, reqs);
    chk(reqs == 0, "R2 mode0 no request", reqs, 0);
    conv_mode = 2'd2;
    quiet_window(300, reqs);
    chk(reqs == 0, "R2 mode2 no request", reqs, 0);
    scan_start = 1'b0; conv_mode = 2'd1;

    // R9 / R6: all enabled channels are outputs
    chan_enable = 8'h0F; pin_is_output = 8'h0F;
    @(negedge clk); scan_start = 1'b1;
    quiet_window(2000, reqs);
    chk(reqs == 0, "R9 empty effective map", reqs, 0);
    scan_start = 1'b0;
    @(negedge clk);

    // Table walk: R1 order/wrap, R4 gap, R5 store, R6 skip, R10 strobe
    foreach (VEC[v]) begin
      chan_enable   = VEC[v][17:10];
      pin_is_output = VEC[v][9:2];
      interval_sel  = VEC[v][1:0];
      eff = chan_enable & ~pin_is_output;
      @(negedge clk);
      scan_start = 1'b1;
      exp_ch = next_exp(eff, 0);
      for (int k = 0; k < 3; k++) begin
        wait_result();
        latest_sel = res_chan;
        #1;
        chk(res_valid == 1'b1, "R10 strobe seen", res_valid, 1);
        chk(int'(res_chan) == exp_ch, "R1 R6 channel order", res_chan, exp_ch);
        chk(res_data == sent_data, "R10 sample on strobe", res_data, sent_data);
        chk(latest_value == sent_data, "R5 latest stored", latest_value, sent_data);
        @(negedge clk);
        chk(res_valid == 1'b0, "R10 single cycle", res_valid, 0);
        if (k < 2) begin
          count_to_req(gap);
          chk(gap + 1 == gap_len(interval_sel) + 1, "R4 interval gap", gap + 1, gap_len(interval_sel) + 1);
          chk(conv_chan == sent_chan || eff != 8'h08 ? 1'b1 : 1'b0, "R11 request channel", conv_chan, sent_chan);
        end
        exp_ch = next_exp(eff, (exp_ch + 1) % NCH);
      end
      scan_start = 1'b0;
      @(negedge clk);
    end

    // R3: halt during the quiet period
    chan_enable = 8'h3C; pin_is_output = 8'h00; interval_sel = 2'd0;
    @(negedge clk); scan_start = 1'b1;
    wait_result();
    @(negedge clk);
    scan_start = 1'b0;
    quiet_window(7000, reqs);
    chk(reqs == 0, "R3 halted scan silent", reqs, 0);

    // R8: restart from lowest channel after start toggle
    chan_enable = 8'hA4;
    @(negedge clk); scan_start = 1'b1;
    wait_result();
    chk(res_chan == 3'd2, "R8 first channel", res_chan, 2);
    @(negedge clk);
    wait_result();
    chk(res_chan == 3'd5, "R1 second channel", res_chan, 5);
    @(negedge clk);
    scan_start = 1'b0;
    @(negedge clk); @(negedge clk);
    scan_start = 1'b1;
    wait_result();
    chk(res_chan == 3'd2, "R8 restart lowest", res_chan, 2);
    latest_sel = 3'd5;
    #1;
    chk(latest_value[11:9] == 3'd5, "R5 other channel retained", latest_value[11:9], 5);
    scan_start = 1'b0;
    repeat (5) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule